// File: doc/BRIEF.md
# Output-Voltage Power-Good Window Monitor

This block decides, once per clock, whether a digitised output voltage sits inside an acceptance band placed around the commanded reference voltage, and drives a registered good flag that a board-level open-drain stage can follow. Both voltages arrive as unsigned millivolt codes. The band reaches 300 mV below the reference and 200 mV above it. For references under 300 mV the lower edge is dropped and only the upper edge is judged. Both edges are formed with saturating arithmetic, so codes near zero or near full scale never wrap.

Transitions are ignored for a while. A reference change, a deep-sleep entry, a slow deep-sleep exit or a fast deep-sleep exit each loads a retriggerable timer. The timer's length in clock cycles comes from the clock rate and a duration in microseconds. While the mask is active, the good flag keeps its last value. If the output sags more than 200 mV under the reference during the mask that follows a sleep entry or a slow sleep exit, the mask is stretched past the timer. It then stays in force until the output is back inside the band.

Top module: `pgood_monitor`

## Requirements
- R1: With no mask active, the good flag equals 1 one clock after the output code satisfies ref-300 <= out <= ref+200 (both limits inclusive), and 0 one clock after it does not.
- R2: An output code above ref+200 clears the good flag when no mask is active.
- R3: When the reference code is below 300, any output code down to 0 counts as good, and only the upper limit applies.
- R4: The upper limit saturates at the largest code (4095 for 12-bit codes), so a reference of 4000 with an output of 4095 counts as good. The lower limit of a 4095 reference is 3795.
- R5: A one-cycle pulse on any of ref_chg, slp_enter, slp_exit_slow or slp_exit_fast raises mask_busy on the next clock. Without a stretch, mask_busy stays high for exactly MASK_CYC cycles, where MASK_CYC = CLK_KHZ*MASK_US/1000.
- R6: A new trigger pulse while the mask runs reloads the full MASK_CYC duration, counted from the new pulse.
- R7: On the clock edge that sees a trigger, and on every edge while mask_busy is high, the good flag keeps its previous value.
- R8: A droop is an output more than 200 below the reference. If a droop is seen while the timer runs after slp_enter or slp_exit_slow, mask_busy stays high after the timer ends. It falls one clock after the first edge, after timer expiry, at which the output is inside the band.
- R9: A droop during a mask started by ref_chg or slp_exit_fast does not stretch the mask.
- R10: While rst_n is low, pgood and mask_busy are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vout_mv | input | VW | Sampled output voltage, millivolts |
| vref_mv | input | VW | Commanded reference voltage, millivolts |
| ref_chg | input | 1 | Reference-change strobe |
| slp_enter | input | 1 | Deep-sleep entry strobe |
| slp_exit_slow | input | 1 | Slow deep-sleep exit strobe |
| slp_exit_fast | input | 1 | Fast deep-sleep exit strobe |
| pgood | output | 1 | Registered window-good flag |
| mask_busy | output | 1 | Fault masking in force |

## Verification
The good flag is registered, so the bench drives codes on a falling edge and reads pgood on the next falling edge, one rising edge later. After a trigger edge, mask_busy is read high on exactly MASK_CYC falling edges and low on the next one. The good flag only follows the band one edge after that, so that is where the bench samples it. In a stretched mask, the band is re-entered on a falling edge. mask_busy is read low one edge later, and pgood is read after a further edge.

// File: rtl/pg_pkg.sv
package pg_pkg;
    // Kind of transition that (re)starts masking
    typedef enum logic [1:0] {
        TRIG_NONE  = 2'd0,
        TRIG_REF   = 2'd1,
        TRIG_SLEEP = 2'd2,
        TRIG_FAST  = 2'd3
    } trig_kind_e;
endpackage

// File: rtl/pg_window.sv
module pg_window #(
    parameter int VW        = 12,
    parameter int BELOW_MV  = 300,
    parameter int ABOVE_MV  = 200,
    parameter int LOWREF_MV = 300,
    parameter int DROOP_MV  = 200
) (
    input  logic [VW-1:0] vout,
    input  logic [VW-1:0] vref,
    output logic          in_win,
    output logic          droop
);
    localparam logic [VW:0] MAXV   = {1'b0, {VW{1'b1}}};
    localparam logic [VW:0] BELOW  = (VW+1)'(BELOW_MV);
    localparam logic [VW:0] ABOVE  = (VW+1)'(ABOVE_MV);
    localparam logic [VW:0] LOWREF = (VW+1)'(LOWREF_MV);
    localparam logic [VW:0] DROOP  = (VW+1)'(DROOP_MV);

    logic [VW:0] out_w, ref_w, hi_sum, hi_bound, lo_bound, dr_bound;
    logic        lo_skip, lo_ok, hi_ok;

    always_comb begin
        out_w    = {1'b0, vout};
        ref_w    = {1'b0, vref};
        hi_sum   = ref_w + ABOVE;
        hi_bound = (hi_sum > MAXV) ? MAXV : hi_sum;
        lo_bound = (ref_w >= BELOW) ? (ref_w - BELOW) : '0;
        dr_bound = (ref_w >= DROOP) ? (ref_w - DROOP) : '0;
        lo_skip  = (ref_w < LOWREF);
        lo_ok    = lo_skip || (out_w >= lo_bound);
        hi_ok    = (out_w <= hi_bound);
        in_win   = lo_ok && hi_ok;
        droop    = (ref_w > DROOP) && (out_w < dr_bound);
    end
endmodule

// File: rtl/pg_mask_timer.sv
module pg_mask_timer #(
    parameter int CNT_MAX = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic running
);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LOAD = CW'(CNT_MAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig)
            st_d.cnt = LOAD;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = (st_q.cnt != '0);

    AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> st_q.cnt == LOAD); // R6
    AST_TIMER_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !trig) |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R5
endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor #(
    parameter int VW      = 12,
    parameter int CLK_KHZ = 100000,
    parameter int MASK_US = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vout_mv,
    input  logic [VW-1:0] vref_mv,
    input  logic          ref_chg,
    input  logic          slp_enter,
    input  logic          slp_exit_slow,
    input  logic          slp_exit_fast,
    output logic          pgood,
    output logic          mask_busy
);
    import pg_pkg::*;

    localparam int MASK_CYC = (CLK_KHZ * MASK_US) / 1000;

    typedef struct packed {
        logic slp_mode;
        logic ext;
        logic good;
    } mon_t;

    mon_t       st_d, st_q;
    trig_kind_e kind;
    logic       trig, in_win, droop, tmr_run, masked_now;

    pg_window #(.VW(VW)) u_win (
        .vout   (vout_mv),
        .vref   (vref_mv),
        .in_win (in_win),
        .droop  (droop)
    );

    pg_mask_timer #(.CNT_MAX(MASK_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .running (tmr_run)
    );

    // Sleep-type triggers take priority so a coincident pulse enables stretching
    always_comb begin
        if (slp_enter || slp_exit_slow) kind = TRIG_SLEEP;
        else if (slp_exit_fast)         kind = TRIG_FAST;
        else if (ref_chg)               kind = TRIG_REF;
        else                            kind = TRIG_NONE;
    end

    assign trig       = (kind != TRIG_NONE);
    assign mask_busy  = tmr_run || st_q.ext;
    assign masked_now = trig || mask_busy;

    always_comb begin
        st_d = st_q;
        case (kind)
            TRIG_SLEEP:           st_d.slp_mode = 1'b1;
            TRIG_FAST, TRIG_REF:  st_d.slp_mode = 1'b0;
            default:              st_d.slp_mode = st_q.slp_mode;
        endcase
        if (tmr_run && st_q.slp_mode && droop)
            st_d.ext = 1'b1;
        else if (!tmr_run && st_q.ext && in_win)
            st_d.ext = 1'b0;
        st_d.good = masked_now ? st_q.good : in_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pgood = st_q.good;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        masked_now |=> $stable(pgood)); // R7
    AST_TRACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !masked_now |=> pgood == $past(in_win)); // R1
    AST_TRIG_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> mask_busy); // R5
    AST_EXT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ext && !in_win) |=> mask_busy); // R8
    AST_NO_FAST_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ext && !st_q.slp_mode && !trig) |=> !st_q.ext); // R9
endmodule

// File: tb/pgood_monitor_tb.sv
module pgood_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VW         = 12;
    localparam int CLK_KHZ    = 1000;
    localparam int MASK_US    = 16;
    localparam int M          = CLK_KHZ * MASK_US / 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vout_mv = '0, vref_mv = '0;
    logic          ref_chg = 0, slp_enter = 0, slp_exit_slow = 0, slp_exit_fast = 0;
    logic          pgood, mask_busy;
    int            n_run = 0, n_fail = 0;
    bit            finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgood_monitor #(.VW(VW), .CLK_KHZ(CLK_KHZ), .MASK_US(MASK_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .vout_mv(vout_mv), .vref_mv(vref_mv),
        .ref_chg(ref_chg), .slp_enter(slp_enter), .slp_exit_slow(slp_exit_slow),
        .slp_exit_fast(slp_exit_fast), .pgood(pgood), .mask_busy(mask_busy));

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // set codes, one edge, check flag
    task automatic win_check(input string req, input int r, input int o, input int exp);
        vref_mv = VW'(r); vout_mv = VW'(o);
        tick();
        check(req, int'(pgood), exp);
    endtask

    // kind: 0 ref_chg, 1 enter, 2 slow exit, 3 fast exit
    task automatic pulse(input int kind);
        case (kind)
            0: ref_chg = 1;
            1: slp_enter = 1;
            2: slp_exit_slow = 1;
            default: slp_exit_fast = 1;
        endcase
        tick();
        ref_chg = 0; slp_enter = 0; slp_exit_slow = 0; slp_exit_fast = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) tick();
        check("R10 pgood in reset", int'(pgood), 0);
        check("R10 mask_busy in reset", int'(mask_busy), 0);
        rst_n = 1;
        tick();
    endtask

    task automatic t_window();
        win_check("R1 centre", 1000, 1000, 1);
        win_check("R1 lower edge", 1000, 700, 1);
        win_check("R1 upper edge", 1000, 1200, 1);
        win_check("R1 below lower", 1000, 699, 0);
        win_check("R2 above upper", 1000, 1201, 0);
        win_check("R1 recover", 1000, 1000, 1);
    endtask

    task automatic t_low_ref();
        win_check("R3 zero output", 250, 0, 1);
        win_check("R3 upper edge", 250, 450, 1);
        win_check("R3 above upper", 250, 451, 0);
        win_check("R3 ref 299 zero out", 299, 0, 1);
    endtask

    task automatic t_saturate();
        win_check("R4 saturated upper", 4000, 4095, 1);
        win_check("R4 top ref lower edge", 4095, 3795, 1);
        win_check("R4 top ref below lower", 4095, 3794, 0);
    endtask

    // trigger with output above the band (no droop); flag must hold then fall
    task automatic t_mask(input int kind, input string tag);
        int busy_cnt;
        int held_ok;
        win_check("R1 pre-mask good", 1000, 1000, 1);
        vout_mv = VW'(1300);
        pulse(kind);
        busy_cnt = 0; held_ok = 1;
        for (int k = 0; k < 4 * M; k++) begin
            if (!mask_busy) break;
            busy_cnt++;
            if (pgood !== 1'b1) held_ok = 0;
            tick();
        end
        check({"R5 mask length ", tag}, busy_cnt, M);
        check({"R7 flag held ", tag}, held_ok, 1);
        check({"R7 flag held at expiry ", tag}, int'(pgood), 1);
        tick();
        check({"R2 flag falls after mask ", tag}, int'(pgood), 0);
        vout_mv = VW'(1000);
        tick();
    endtask

    task automatic t_retrigger();
        int busy_cnt;
        win_check("R1 pre-retrigger", 1000, 1000, 1);
        pulse(0);
        repeat (M / 2 - 1) tick();
        pulse(0);
        busy_cnt = 0;
        for (int k = 0; k < 4 * M; k++) begin
            if (!mask_busy) break;
            busy_cnt++;
            tick();
        end
        check("R6 reload full duration", busy_cnt, M);
        tick();
    endtask

    task automatic t_extend(input int kind, input string tag);
        win_check("R1 pre-extend", 1000, 1000, 1);
        vout_mv = VW'(600);
        pulse(kind);
        repeat (2 * M) tick();
        check({"R8 mask stretched ", tag}, int'(mask_busy), 1);
        check({"R7 flag held in stretch ", tag}, int'(pgood), 1);
        vout_mv = VW'(1000);
        tick();
        check({"R8 stretch ends ", tag}, int'(mask_busy), 0);
        vout_mv = VW'(1250);
        tick();
        check({"R8 flag live after stretch ", tag}, int'(pgood), 0);
        vout_mv = VW'(1000);
        tick();
    endtask

    task automatic t_no_extend(input int kind, input string tag);
        int busy_cnt;
        win_check("R1 pre-no-extend", 1000, 1000, 1);
        vout_mv = VW'(600);
        pulse(kind);
        busy_cnt = 0;
        for (int k = 0; k < 4 * M; k++) begin
            if (!mask_busy) break;
            busy_cnt++;
            tick();
        end
        check({"R9 no stretch ", tag}, busy_cnt, M);
        tick();
        check({"R9 flag falls ", tag}, int'(pgood), 0);
        vout_mv = VW'(1000);
        tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_window();
        t_low_ref();
        t_saturate();
        t_mask(0, "ref_chg");
        t_mask(1, "enter");
        t_mask(2, "slow exit");
        t_mask(3, "fast exit");
        t_retrigger();
        t_extend(1, "enter");
        t_extend(2, "slow exit");
        t_no_extend(0, "ref_chg");
        t_no_extend(3, "fast exit");
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule